// File: doc/BRIEF.md
# Programmable Sync Pulse Burst Generator

This block drives a single sync lane from an internal divided clock. Software programs it through a two-entry byte register interface. One register holds an output mode, and the other holds a 2-bit burst-length code. In burst mode, every write to the length register launches a finite train of pulses: code `c` gives `2^c` pulses. In continuous mode, the lane carries the divided clock without end, and the length code has no effect. A power-enable input gates the whole function: with it low, the lane and the busy flag stay low.

Each pulse is one high half of the internal divider period (`DIV` cycles, high for `DIV/2`). Consecutive pulses are one whole divider period apart. A write that lands during a burst never shortens the pulse in flight. The new length takes over once that pulse has completed, and that many further pulses follow. A busy flag marks the span from the trigger to the falling edge of the burst's last pulse.

Top module: `sync_burst_gen`

## Requirements
- R1: After reset the length register (`reg_sel`=0) reads 0x03, the mode register (`reg_sel`=1) reads 0x00, and `sync_out` and `busy` are low.
- R2: Only bits [1:0] of each register are stored. Bits [7:2] read as 0 regardless of what was written to them.
- R3: In burst mode with power on, a length write with code `c` in bits [1:0] produces exactly `2^c` pulses (code 0→1, 1→2, 2→4, 3→8). `sync_out` and `busy` go high in the cycle after the write. Each pulse is high for `DIV/2` cycles, and pulse starts are `DIV` cycles apart. `busy` stays high for `(2^c-1)*DIV + DIV/2` cycles, and `sync_out` stays low after the burst.
- R4: The mode register bits [1:0] encode 0 = off, 1 = continuous, 2 = burst, 3 = off. Only a length write made while the mode is burst and power is on raises `busy`. In off modes, `sync_out` and `busy` stay low.
- R5: While `pwr_en` is low, `sync_out` and `busy` are low in every mode, and a length write launches nothing.
- R6: In continuous mode with power on, `sync_out` is high for the first `DIV/2` cycles of each `DIV`-cycle period, starting in the cycle after the mode write. `busy` stays low, and length writes do not disturb the waveform.
- R7: A length write during a burst never truncates the pulse in progress. If the write falls in period `p` of the burst (counting from 0), the burst ends after `p+1+2^c` pulses in total.
- R8: A burst is abandoned at once when the mode leaves burst, or when `pwr_en` drops. `busy` and `sync_out` are then low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_en | input | 1 | Power-up enable of the sync function |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 length, 1 mode |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the selected register |
| sync_out | output | 1 | Sync pulse lane |
| busy | output | 1 | High from trigger to the end of the last pulse |

## Verification
The bench aims its rewrites at three points in the pulse train: at the last cycle of a pulse, in the middle of a high phase, and in a low phase. A design that truncated the pulse in flight would fail the pulse-width check. A design that restarted the count from the wrong place would report the wrong pulse total or busy length. Every code is run, to catch an off-by-one in the power-of-two decode (seven pulses instead of eight, or two for code 0). Aborts by a mode change and by dropping power are checked to be immediate. Continuous mode is checked to ignore length writes, and powered-down writes are checked to launch no hidden burst.

// File: rtl/sbg_pkg.sv
package sbg_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF   = 2'd0,
    MODE_CONT  = 2'd1,
    MODE_BURST = 2'd2,
    MODE_SPARE = 2'd3
  } mode_e;
endpackage

// File: rtl/sbg_regs.sv
module sbg_regs
  import sbg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output mode_e             mode_q,
  output logic              len_wr,
  output logic [CODE_W-1:0] wr_code
);
  logic [CODE_W-1:0] code_q, code_n;
  mode_e             mode_n;
  logic              code_en, mode_en;

  assign code_en = wr_en && !sel;
  assign mode_en = wr_en && sel;
  assign len_wr  = code_en;
  assign wr_code = wdata[CODE_W-1:0];

  always_comb begin
    code_n = code_q;
    mode_n = mode_q;
    if (code_en) code_n = wdata[CODE_W-1:0];
    if (mode_en) mode_n = mode_e'(wdata[MODE_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '1;
      mode_q <= MODE_OFF;
    end else begin
      code_q <= code_n;
      mode_q <= mode_n;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel) rdata[MODE_W-1:0] = mode_q;
    else     rdata[CODE_W-1:0] = code_q;
  end
endmodule

// File: rtl/sbg_divider.sv
module sbg_divider #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic start,
  output logic hi_phase,
  output logic pulse_end
);
  localparam int HIGH  = DIV / 2;
  localparam int DIV_W = (DIV > 2) ? $clog2(DIV) : 1;

  logic [DIV_W-1:0] cnt_q, cnt_n;

  always_comb begin
    if (start)     cnt_n = '0;
    else if (run)  cnt_n = (cnt_q == DIV_W'(DIV - 1)) ? '0 : cnt_q + DIV_W'(1);
    else           cnt_n = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign hi_phase  = cnt_q < DIV_W'(HIGH);
  assign pulse_end = cnt_q == DIV_W'(HIGH - 1);
endmodule

// File: rtl/sbg_burst_ctrl.sv
module sbg_burst_ctrl #(
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              trig,
  input  logic [CODE_W-1:0] code,
  input  logic              hi_phase,
  input  logic              pulse_end,
  output logic              busy_q,
  output logic              start
);
  localparam int LEFT_W = 1 << CODE_W;

  logic [LEFT_W-1:0] left_q, left_n;
  logic              busy_n;
  logic              pend_q, pend_n;
  logic [CODE_W-1:0] pcode_q, pcode_n;

  function automatic logic [LEFT_W-1:0] pulses_of(input logic [CODE_W-1:0] c);
    logic [LEFT_W-1:0] r;
    r    = '0;
    r[c] = 1'b1;
    return r;
  endfunction

  always_comb begin
    busy_n  = busy_q;
    left_n  = left_q;
    pend_n  = pend_q;
    pcode_n = pcode_q;
    start   = 1'b0;
    if (!enable) begin
      busy_n = 1'b0;
      pend_n = 1'b0;
    end else if (!busy_q) begin
      if (trig) begin
        busy_n = 1'b1;
        left_n = pulses_of(code);
        pend_n = 1'b0;
        start  = 1'b1;
      end
    end else if (pulse_end) begin
      if (trig) begin
        left_n = pulses_of(code);
        pend_n = 1'b0;
      end else if (pend_q) begin
        left_n = pulses_of(pcode_q);
        pend_n = 1'b0;
      end else if (left_q == LEFT_W'(1)) begin
        busy_n = 1'b0;
      end else begin
        left_n = left_q - LEFT_W'(1);
      end
    end else if (trig) begin
      if (hi_phase) begin
        pend_n  = 1'b1;
        pcode_n = code;
      end else begin
        left_n = pulses_of(code);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      left_q  <= '0;
      pend_q  <= 1'b0;
      pcode_q <= '0;
    end else begin
      busy_q  <= busy_n;
      left_q  <= left_n;
      pend_q  <= pend_n;
      pcode_q <= pcode_n;
    end
  end
endmodule

// File: rtl/sync_burst_gen.sv
module sync_burst_gen
  import sbg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CODE_W = 2,
  parameter int DIV    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_en,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              sync_out,
  output logic              busy
);
  mode_e             mode_q;
  logic              len_wr;
  logic [CODE_W-1:0] wr_code;
  logic              burst_ok, cont_act;
  logic              busy_q, start;
  logic              hi_phase, pulse_end;

  sbg_regs #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .sel(reg_sel),
    .wdata(reg_wdata), .rdata(reg_rdata), .mode_q(mode_q),
    .len_wr(len_wr), .wr_code(wr_code)
  );

  assign burst_ok = pwr_en && (mode_q == MODE_BURST);
  assign cont_act = pwr_en && (mode_q == MODE_CONT);

  sbg_burst_ctrl #(.CODE_W(CODE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(burst_ok), .trig(len_wr),
    .code(wr_code), .hi_phase(hi_phase), .pulse_end(pulse_end),
    .busy_q(busy_q), .start(start)
  );

  assign busy = busy_q && burst_ok;

  sbg_divider #(.DIV(DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy || cont_act), .start(start),
    .hi_phase(hi_phase), .pulse_end(pulse_end)
  );

  assign sync_out = (busy || cont_act) && hi_phase;
endmodule

// File: rtl/sbg_checker.sv
module sbg_checker #(
  parameter int DATA_W = 8,
  parameter int CODE_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_en,
  input logic              reg_wr,
  input logic              reg_sel,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [1:0]        mode,
  input logic              busy,
  input logic              sync_out
);
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_wdata[DATA_W-1:CODE_W] != '0)) |=> (reg_rdata[DATA_W-1:CODE_W] == '0));

  p_first_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> sync_out);

  p_launch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_wr && !reg_sel && pwr_en && mode == 2'd2));

  p_off_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 || mode == 2'd3) |-> (!sync_out && !busy));

  p_nopower_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |-> (!sync_out && !busy));

  p_cont_nobusy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1) |-> !busy);

  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_sel && reg_wdata[1:0] != 2'd2) |=> !busy);
endmodule

bind sync_burst_gen sbg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .reg_wr(reg_wr),
  .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .mode(mode_q), .busy(busy), .sync_out(sync_out)
);

// File: tb/sync_burst_gen_test.sv
`timescale 1ns/1ps
module sync_burst_gen_test;
  localparam int DIV  = 8;
  localparam int HIGH = DIV / 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_en = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_sel = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       sync_out, busy;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  int    q_pulses[$];
  int    q_blen[$];
  string q_tag[$];

  bit mon_on = 1'b0;
  bit chk_width = 1'b1;
  bit prev_out = 1'b0, prev_busy = 1'b0;
  int pcount = 0, blen = 0, hwidth = 0;

  always #2 clk = ~clk;

  sync_burst_gen #(.DATA_W(8), .CODE_W(2), .DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sync_out(sync_out), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push_exp(input int pulses, input int bl, input string tag);
    q_pulses.push_back(pulses);
    q_blen.push_back(bl);
    q_tag.push_back(tag);
  endtask

  // monitor: scoreboard side
  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      if (busy) blen++;
      if (sync_out && !prev_out && busy) pcount++;
      if (prev_out && !sync_out && prev_busy && chk_width)
        check(hwidth == HIGH, "R3", "pulse width", hwidth, HIGH);
      hwidth = sync_out ? hwidth + 1 : 0;
      if (prev_busy && !busy) begin
        if (q_pulses.size() == 0) begin
          check(1'b0, "R4", "unexpected burst", pcount, 0);
        end else begin
          int ep, eb;
          string tg;
          ep = q_pulses.pop_front();
          eb = q_blen.pop_front();
          tg = q_tag.pop_front();
          check(pcount == ep, tg, "pulse count", pcount, ep);
          check(blen == eb, tg, "busy length", blen, eb);
        end
        pcount = 0;
        blen = 0;
      end
      prev_out = sync_out;
      prev_busy = busy;
    end
  end

  task automatic wr_now(input bit sel, input logic [7:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wr(input bit sel, input logic [7:0] d);
    @(negedge clk);
    wr_now(sel, d);
  endtask

  task automatic wait_idle(input string req);
    int k = 0;
    while (busy && k < 1000) begin
      @(negedge clk);
      k++;
    end
    check(k < 1000, req, "burst never ended", k, 0);
    repeat (2) @(negedge clk);
    check(!sync_out && !busy, req, "lane low after burst", int'(sync_out), 0);
  endtask

  initial begin
    #(4.0 * 200000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    reg_sel = 1'b0; #1;
    check(reg_rdata == 8'h03, "R1", "length reset", reg_rdata, 3);
    reg_sel = 1'b1; #1;
    check(reg_rdata == 8'h00, "R1", "mode reset", reg_rdata, 0);
    check(!sync_out && !busy, "R1", "outputs at reset", int'(sync_out) + int'(busy), 0);
    pwr_en = 1'b1;
    mon_on = 1'b1;

    // R2 reserved bits; R4 no launch in off mode
    wr(1'b0, 8'hFD);
    reg_sel = 1'b0; #1;
    check(reg_rdata == 8'h01, "R2", "length reserved bits", reg_rdata, 1);
    check(!busy, "R4", "off mode write launches nothing", int'(busy), 0);
    wr(1'b1, 8'hFE);
    reg_sel = 1'b1; #1;
    check(reg_rdata == 8'h02, "R2", "mode reserved bits", reg_rdata, 2);
    reg_sel = 1'b0; #1;
    check(reg_rdata == 8'h01, "R2", "length kept", reg_rdata, 1);

    // R3 every code
    for (int c = 0; c < 4; c++) begin
      push_exp(1 << c, ((1 << c) - 1) * DIV + HIGH, "R3");
      wr(1'b0, 8'(c));
      check(sync_out && busy, "R3", "burst starts next cycle", int'(sync_out) + int'(busy), 2);
      wait_idle("R3");
    end

    // R7 rewrites: end of pulse, high phase, low phase
    begin
      int js[3];
      int nc[3];
      js[0] = HIGH - 1;       nc[0] = 0;
      js[1] = DIV + 1;        nc[1] = 1;
      js[2] = DIV + HIGH + 1; nc[2] = 2;
      for (int i = 0; i < 3; i++) begin
        int p;
        p = js[i] / DIV;
        push_exp(p + 1 + (1 << nc[i]), (p + (1 << nc[i])) * DIV + HIGH, "R7");
        wr(1'b0, 8'h03);
        repeat (js[i]) @(negedge clk);
        wr_now(1'b0, 8'(nc[i]));
        wait_idle("R7");
      end
    end

    // R8 abort by mode change
    chk_width = 1'b0;
    push_exp(3, 2 * DIV + 2, "R8");
    wr(1'b0, 8'h03);
    repeat (2 * DIV + 1) @(negedge clk);
    wr_now(1'b1, 8'h00);
    check(!busy && !sync_out, "R8", "mode abort", int'(busy) + int'(sync_out), 0);
    repeat (2) @(negedge clk);
    // R8 abort by power drop
    wr(1'b1, 8'h02);
    push_exp(2, DIV + 3, "R8");
    wr(1'b0, 8'h03);
    repeat (DIV + 2) @(negedge clk);
    #1 pwr_en = 1'b0;
    @(negedge clk);
    check(!busy && !sync_out, "R8", "power abort", int'(busy) + int'(sync_out), 0);
    repeat (2) @(negedge clk);
    chk_width = 1'b1;

    // R5 powered down
    bad = 0;
    wr(1'b0, 8'h02);
    for (int j = 0; j < 2 * DIV; j++) begin
      if (busy || sync_out) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R5", "burst write while unpowered", bad, 0);
    wr(1'b1, 8'h01);
    bad = 0;
    for (int j = 0; j < 2 * DIV; j++) begin
      if (busy || sync_out) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R5", "continuous while unpowered", bad, 0);

    // R6 continuous with power
    wr(1'b1, 8'h00);
    pwr_en = 1'b1;
    wr(1'b1, 8'h01);
    bad = 0;
    for (int j = 0; j < 3 * DIV; j++) begin
      if (sync_out != ((j % DIV) < HIGH) || busy) bad++;
      if (j == DIV) begin
        reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 8'h02;
      end else begin
        reg_wr = 1'b0;
      end
      @(negedge clk);
    end
    check(bad == 0, "R6", "continuous waveform", bad, 0);
    reg_sel = 1'b0; #1;
    check(reg_rdata == 8'h02, "R6", "length stored in continuous", reg_rdata, 2);
    wr(1'b1, 8'h03);
    @(negedge clk);
    check(!sync_out && !busy, "R4", "spare mode quiet", int'(sync_out), 0);

    check(q_pulses.size() == 0, "R3", "expected bursts left", q_pulses.size(), 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule